// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block builds a three-byte Hamming check word for every 256-byte frame of NAND page data. Data arrives one byte per cycle on a valid/ready stream. A 512-byte sector is handled as two frames back to back. The engine folds each byte into line-parity and column-parity accumulators as it is accepted. One cycle after the last byte of a frame, it presents that frame's check word.

With checking enabled, the block also compares the computed word against the check word that was stored with the data. It then classifies the frame in one of four ways:
- clean;
- a single flipped data bit, whose byte address and bit index it reports;
- a fault inside the stored check word itself;
- damage too heavy to repair.

A runtime switch picks between two packings of the check word, which differ only in the order of its first two bytes.

A sector begins with a one-cycle `frame_start` pulse. Back-pressure rules:
- `in_ready` is low during that pulse.
- `in_ready` is low after reset.
- `in_ready` stays low once all bytes of a sector have been taken, until the next pulse.
- A byte is consumed only on a cycle where both `in_valid` and `in_ready` are high.
- `in_data` must be held while `in_valid` is high and `in_ready` is low.

Top module: `hamming_frame_ecc`

## Requirements
- R1: The check word is 24 bits, with byte k at bits [8k+7:8k]. It is laid out as follows:
  - For byte-address bit k (0..7), the even-half parity lies at bit 2k and the odd-half parity at bit 2k+1.
  - For bit-index bit j (0..2), the even-half column parity lies at bit 18+2j and the odd-half parity at bit 19+2j.
  - Bits 17:16 read 1.
  - All parity bits are stored inverted.
  - The odd-half parity is the XOR of all data bits whose byte address (or bit index) has that bit set. The even-half parity covers the data bits where that bit is clear.
- R2: A frame of 256 bytes of 0xFF yields the check word 0xFFFFFF.
- R3: Each sector is two frames of 256 bytes. `done` pulses for one cycle in the cycle after the 256th byte of a frame is accepted. At that point `frame_idx` gives the frame number (0, then 1) and `ecc_out` holds the word. Parity restarts for the second frame.
- R4: When `swap_order` is 1, bytes 0 and 1 of the word are exchanged, both in `ecc_out` and in how the stored word is read. Byte 2 never moves.
- R5: `chk_ecc` holds the stored words, frame f at bits [24f+23:24f], in the same packing as `ecc_out`. With `check_en` at 1 and a matching stored word, `status` is 0 (clean).
- R6: With exactly one data bit flipped relative to the stored word, `status` is 1. `err_byte` gives the byte address within the frame and `err_bit` the bit index. With any other status, both position outputs read 0.
- R7: With exactly one of the 22 parity bits of the stored word flipped, `status` is 2. The data is reported as intact.
- R8: Any other mismatch, such as two flipped data bits, gives `status` 3.
- R9: With `check_en` at 0, `status` is 0 whatever `chk_ecc` holds.
- R10: `in_ready` is low during a `frame_start` cycle and after all 512 bytes of a sector. Bytes offered while `in_ready` is low are not consumed.
- R11: A `frame_start` pulse partway through a sector raises `short_frame` for one cycle. It also discards the partial parity, and the new sector starts clean.
- R12: After reset, `done`, `short_frame`, `status`, `ecc_out` and `in_ready` are 0, and the block waits for `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse that opens a sector |
| check_en | input | 1 | Compare against stored word when 1 |
| swap_order | input | 1 | Exchange check-word bytes 0 and 1 |
| chk_ecc | input | 48 | Stored check words, frame 0 in the low 24 bits |
| in_valid | input | 1 | Data byte offered |
| in_ready | output | 1 | Engine can take a byte |
| in_data | input | 8 | Data byte |
| done | output | 1 | Frame finished, results valid |
| frame_idx | output | 1 | Frame number of the result |
| ecc_out | output | 24 | Computed check word |
| status | output | 2 | 0 clean, 1 data bit fixed, 2 check-word fault, 3 uncorrectable |
| err_byte | output | 8 | Byte address of the flipped bit |
| err_bit | output | 3 | Bit index of the flipped bit |
| short_frame | output | 1 | Sector restarted before completion |

## Verification
The assertions assume the following:
- `frame_start` is a single-cycle pulse.
- `check_en` is steady through the last byte of each frame.
- The stored word on `chk_ecc` does not change while a frame is in progress.

The stimulus sets the mode pins and stored words before each pulse and holds them for the whole sector. It drops `in_valid` at random but keeps the data stable while a byte is waiting. It sends further bytes only when testing that the stream is held off at the end of a sector.

// File: rtl/hfe_pkg.sv
package hfe_pkg;
  localparam int AW       = 8;               // byte-address bits per frame
  localparam int BW       = 3;               // bit-index bits per byte
  localparam int FR_BYTES = 1 << AW;
  localparam int NPAIR    = AW + BW;
  localparam int CW       = 24;
  localparam logic [CW-1:0] USED_MASK = 24'hFCFFFF;

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'd0,
    ST_FIXED  = 2'd1,
    ST_ECCBAD = 2'd2,
    ST_FATAL  = 2'd3
  } hfe_status_e;

  // position of the even member of parity pair i
  function automatic int pbase(input int i);
    return (i < AW) ? 2 * i : 2 * i + 2;
  endfunction

  function automatic logic [CW-1:0] byte_swap01(input logic [CW-1:0] w);
    return {w[23:16], w[7:0], w[15:8]};
  endfunction

  function automatic logic [CW-1:0] hfe_pack(input logic [AW-1:0] lp_e,
                                             input logic [AW-1:0] lp_o,
                                             input logic [7:0]    col);
    logic [CW-1:0] raw;
    logic [7:0] om;
    raw = '0;
    for (int k = 0; k < AW; k++) begin
      raw[pbase(k)]     = lp_e[k];
      raw[pbase(k) + 1] = lp_o[k];
    end
    for (int j = 0; j < BW; j++) begin
      for (int b = 0; b < 8; b++) om[b] = b[j];
      raw[pbase(AW + j)]     = ^(col & ~om);
      raw[pbase(AW + j) + 1] = ^(col & om);
    end
    return ~raw;
  endfunction
endpackage

// File: rtl/hfe_accum.sv
module hfe_accum
  import hfe_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic          wrap,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    data,
  output logic [AW-1:0] lp_e_f,
  output logic [AW-1:0] lp_o_f,
  output logic [7:0]    col_f
);
  logic [AW-1:0] lp_e_q, lp_o_q;
  logic [7:0]    col_q;
  logic          bpar;

  assign bpar = take & (^data);

  for (genvar k = 0; k < AW; k++) begin : g_line
    assign lp_o_f[k] = lp_o_q[k] ^ (bpar &  addr[k]);
    assign lp_e_f[k] = lp_e_q[k] ^ (bpar & ~addr[k]);
  end

  assign col_f = col_q ^ (take ? data : 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_e_q <= '0;
      lp_o_q <= '0;
      col_q  <= '0;
    end else if (clr || (take && wrap)) begin
      lp_e_q <= '0;
      lp_o_q <= '0;
      col_q  <= '0;
    end else if (take) begin
      lp_e_q <= lp_e_f;
      lp_o_q <= lp_o_f;
      col_q  <= col_f;
    end
  end
endmodule

// File: rtl/hfe_decode.sv
module hfe_decode
  import hfe_pkg::*;
(
  input  logic [CW-1:0] calc,
  input  logic [CW-1:0] stored,
  output hfe_status_e   status,
  output logic [AW-1:0] pos_byte,
  output logic [BW-1:0] pos_bit
);
  logic [CW-1:0]    diff;
  logic [NPAIR-1:0] pair_x, odd_b;

  always_comb begin
    diff = (calc ^ stored) & USED_MASK;
    for (int i = 0; i < NPAIR; i++) begin
      pair_x[i] = diff[pbase(i)] ^ diff[pbase(i) + 1];
      odd_b[i]  = diff[pbase(i) + 1];
    end
    pos_byte = '0;
    pos_bit  = '0;
    if (diff == '0)                  status = ST_CLEAN;
    else if (&pair_x) begin
      status   = ST_FIXED;
      pos_byte = odd_b[AW-1:0];
      pos_bit  = odd_b[NPAIR-1:AW];
    end
    else if ($countones(diff) == 1)  status = ST_ECCBAD;
    else                             status = ST_FATAL;
  end
endmodule

// File: rtl/hamming_frame_ecc.sv
module hamming_frame_ecc
  import hfe_pkg::*;
#(
  parameter  int FRAMES = 2,
  localparam int FIW    = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 check_en,
  input  logic                 swap_order,
  input  logic [FRAMES*24-1:0] chk_ecc,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [7:0]           in_data,
  output logic                 done,
  output logic [FIW-1:0]       frame_idx,
  output logic [23:0]          ecc_out,
  output logic [1:0]           status,
  output logic [7:0]           err_byte,
  output logic [2:0]           err_bit,
  output logic                 short_frame
);
  localparam int SECTOR = FRAMES * FR_BYTES;
  localparam int CNTW   = $clog2(SECTOR) + 1;

  logic [CNTW-1:0] cnt_q;
  logic [AW-1:0]   addr;
  logic [FIW-1:0]  fidx;
  logic            take, last, idle;
  logic [AW-1:0]   lp_e_f, lp_o_f;
  logic [7:0]      col_f;
  logic [CW-1:0]   calc_c, stored_raw, stored_c;
  hfe_status_e     dec_st;
  logic [AW-1:0]   dec_byte;
  logic [BW-1:0]   dec_bit;

  assign idle     = (cnt_q == CNTW'(SECTOR));
  assign in_ready = !idle && !frame_start;
  assign take     = in_valid && in_ready;
  assign addr     = cnt_q[AW-1:0];
  if (FRAMES > 1) begin : g_fidx
    assign fidx = cnt_q[AW +: FIW];
  end else begin : g_fidx1
    assign fidx = 1'b0;
  end
  assign last = take && (addr == {AW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= CNTW'(SECTOR);
    else if (frame_start) cnt_q <= '0;
    else if (take)        cnt_q <= cnt_q + 1'b1;
  end

  hfe_accum u_acc (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .take(take), .wrap(last),
    .addr(addr), .data(in_data),
    .lp_e_f(lp_e_f), .lp_o_f(lp_o_f), .col_f(col_f)
  );

  assign calc_c     = hfe_pack(lp_e_f, lp_o_f, col_f);
  assign stored_raw = chk_ecc[int'(fidx)*24 +: 24];
  assign stored_c   = swap_order ? byte_swap01(stored_raw) : stored_raw;

  hfe_decode u_dec (
    .calc(calc_c), .stored(stored_c),
    .status(dec_st), .pos_byte(dec_byte), .pos_bit(dec_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done        <= 1'b0;
      frame_idx   <= '0;
      ecc_out     <= '0;
      status      <= 2'd0;
      err_byte    <= '0;
      err_bit     <= '0;
      short_frame <= 1'b0;
    end else begin
      done        <= last;
      short_frame <= frame_start && !idle && (cnt_q != '0);
      if (last) begin
        frame_idx <= fidx;
        ecc_out   <= swap_order ? byte_swap01(calc_c) : calc_c;
        if (check_en) begin
          status   <= dec_st;
          err_byte <= dec_byte;
          err_bit  <= dec_bit;
        end else begin
          status   <= ST_CLEAN;
          err_byte <= '0;
          err_bit  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/hfe_chk.sv
module hfe_chk #(
  parameter int FRAMES = 2,
  parameter int FIW    = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           frame_start,
  input logic           check_en,
  input logic           in_ready,
  input logic           done,
  input logic [FIW-1:0] frame_idx,
  input logic [23:0]    ecc_out,
  input logic [1:0]     status,
  input logic [7:0]     err_byte,
  input logic [2:0]     err_bit,
  input logic           short_frame
);
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && frame_idx == FIW'(FRAMES - 1)) |=> !in_ready);

  p_start_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !in_ready);

  p_check_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(check_en)) |-> status == 2'd0);

  p_pos_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != 2'd1) |-> (err_byte == 8'd0 && err_bit == 3'd0));

  p_pad_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ecc_out[17:16] == 2'b11);

  p_short_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    short_frame |-> $past(frame_start));
endmodule

bind hamming_frame_ecc hfe_chk #(.FRAMES(FRAMES), .FIW(FIW)) u_chk (.*);

// File: tb/sim_hamming_frame_ecc.sv
module sim_hamming_frame_ecc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0, check_en = 1'b0, swap_order = 1'b0;
  logic [47:0] chk_ecc = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, done, short_frame;
  logic [0:0]  frame_idx;
  logic [23:0] ecc_out;
  logic [1:0]  status;
  logic [7:0]  err_byte;
  logic [2:0]  err_bit;

  always #2.5 clk = ~clk;

  hamming_frame_ecc u0 (.*);

  int errors = 0, checks = 0, n_done = 0, n_short = 0, cycles = 0;
  logic [7:0]  mem [0:511];
  logic [0:0]  cap_idx [0:3];
  logic [23:0] cap_ecc [0:3];
  logic [1:0]  cap_st  [0:3];
  logic [7:0]  cap_byte[0:3];
  logic [2:0]  cap_bit [0:3];

  always @(negedge clk) begin
    if (done) begin
      if (n_done < 4) begin
        cap_idx[n_done] = frame_idx; cap_ecc[n_done] = ecc_out;
        cap_st[n_done] = status; cap_byte[n_done] = err_byte; cap_bit[n_done] = err_bit;
      end
      n_done++;
    end
    if (short_frame) n_short++;
  end

  task automatic report_sum();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
        report_sum();
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // canonical check word straight from the parity definition (R1)
  function automatic logic [23:0] ref_ecc(input int base);
    logic [7:0] le = '0, lo = '0;
    logic [2:0] ce = '0, co = '0;
    logic [23:0] raw = '0;
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 8; b++)
        if (mem[base + a][b]) begin
          for (int k = 0; k < 8; k++) if (a[k]) lo[k] ^= 1'b1; else le[k] ^= 1'b1;
          for (int j = 0; j < 3; j++) if (b[j]) co[j] ^= 1'b1; else ce[j] ^= 1'b1;
        end
    for (int k = 0; k < 8; k++) begin raw[2*k] = le[k]; raw[2*k+1] = lo[k]; end
    for (int j = 0; j < 3; j++) begin raw[18+2*j] = ce[j]; raw[19+2*j] = co[j]; end
    return ~raw;
  endfunction

  function automatic logic [23:0] lay(input logic [23:0] w, input bit sw);
    return sw ? {w[23:16], w[7:0], w[15:8]} : w;
  endfunction

  task automatic pulse_start();
    @(negedge clk);
    frame_start = 1'b1; in_valid = 1'b0;
    #1;
    chk(in_ready == 1'b0, "R10 ready low during start", in_ready, 0);
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic stream(input int n);
    int i = 0;
    while (i < n) begin
      @(negedge clk);
      in_valid = ($urandom % 4) != 0;
      in_data  = mem[i];
      #1;
      if (in_valid && in_ready) i++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic sector(input bit ce, input bit sw, input logic [47:0] st);
    check_en = ce; swap_order = sw; chk_ecc = st;
    n_done = 0;
    pulse_start();
    stream(512);
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_frames(input string req, input bit sw,
                               input logic [1:0] s0, input logic [1:0] s1);
    logic [23:0] e;
    chk(n_done == 2, {req, " R3 done count"}, n_done, 2);
    for (int f = 0; f < 2; f++) begin
      e = lay(ref_ecc(f * 256), sw);
      chk(cap_idx[f] == f[0], {req, " R3 frame index"}, cap_idx[f], f);
      chk(cap_ecc[f] == e, {req, " R1 R4 check word"}, cap_ecc[f], e);
      chk(cap_st[f] == (f == 0 ? s0 : s1), {req, " status"}, cap_st[f], f == 0 ? s0 : s1);
    end
  endtask

  function automatic logic [47:0] good_store(input bit sw);
    return {lay(ref_ecc(256), sw), lay(ref_ecc(0), sw)};
  endfunction

  task automatic fill_random();
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
  endtask

  initial begin
    logic [47:0] st;
    int f, a, b, p, a2, b2;
    void'($urandom(32'd7411));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(done == 0 && short_frame == 0, "R12 done/short at reset", {done, short_frame}, 0);
    chk(status == 0 && ecc_out == 0, "R12 status/ecc at reset", ecc_out, 0);
    chk(in_ready == 0, "R12 ready low at reset", in_ready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(in_ready == 0, "R12 waits for start", in_ready, 0);

    // R2 erased sector
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    sector(0, 0, '0);
    chk(cap_ecc[0] == 24'hFFFFFF && cap_ecc[1] == 24'hFFFFFF, "R2 erased word",
        cap_ecc[0], 24'hFFFFFF);
    expect_frames("R2", 0, 0, 0);

    // R1 R3 R4 random generate mode, both packings
    for (int t = 0; t < 6; t++) begin
      fill_random();
      sector(0, t[0], '0);
      expect_frames("R1 gen", t[0], 0, 0);
    end

    // R5 clean check, both packings
    for (int t = 0; t < 4; t++) begin
      fill_random();
      sector(1, t[0], good_store(t[0]));
      expect_frames("R5 clean", t[0], 0, 0);
    end

    // R6 single data bit, directed corners then random
    for (int t = 0; t < 8; t++) begin
      fill_random();
      st = good_store(t[1]);
      f = t[0];
      a = (t == 0) ? 0 : (t == 1) ? 255 : int'($urandom % 256);
      b = (t == 0) ? 0 : (t == 1) ? 7 : int'($urandom % 8);
      mem[f * 256 + a][b] = ~mem[f * 256 + a][b];
      sector(1, t[1], st);
      chk(cap_st[f] == 2'd1, "R6 fixed status", cap_st[f], 1);
      chk(cap_byte[f] == a[7:0] && cap_bit[f] == b[2:0], "R6 position",
          {cap_byte[f], cap_bit[f]}, {a[7:0], b[2:0]});
      chk(cap_st[1-f] == 2'd0 && cap_byte[1-f] == 0, "R6 other frame clean",
          cap_st[1-f], 0);
    end

    // R7 single flipped stored parity bit
    for (int t = 0; t < 6; t++) begin
      fill_random();
      f = t % 2;
      p = int'($urandom % 22);
      if (p >= 16) p += 2;
      st = {ref_ecc(256), ref_ecc(0)};
      st[f * 24 + p] = ~st[f * 24 + p];
      st = {lay(st[47:24], t[1]), lay(st[23:0], t[1])};
      sector(1, t[1], st);
      chk(cap_st[f] == 2'd2, "R7 check-word fault", cap_st[f], 2);
      chk(cap_byte[f] == 0 && cap_bit[f] == 0, "R7 data untouched",
          {cap_byte[f], cap_bit[f]}, 0);
    end

    // R8 two flipped data bits
    for (int t = 0; t < 5; t++) begin
      fill_random();
      st = good_store(0);
      a = int'($urandom % 256); b = int'($urandom % 8);
      a2 = (a + 1 + int'($urandom % 255)) % 256; b2 = int'($urandom % 8);
      if (t == 0) begin a = 0; b = 0; a2 = 255; b2 = 7; end
      mem[a][b] = ~mem[a][b];
      mem[a2][b2] = ~mem[a2][b2];
      sector(1, 0, st);
      chk(cap_st[0] == 2'd3, "R8 uncorrectable", cap_st[0], 3);
    end

    // R9 check disabled with a wrong stored word
    fill_random();
    sector(0, 0, ~good_store(0));
    chk(cap_st[0] == 0 && cap_st[1] == 0, "R9 status when disabled", {cap_st[0], cap_st[1]}, 0);

    // R10 hold-off after a full sector
    fill_random();
    sector(0, 0, '0);
    n_done = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'h5A;
      #1;
      chk(in_ready == 0, "R10 ready low after sector", in_ready, 0);
    end
    @(negedge clk); in_valid = 1'b0;
    chk(n_done == 0, "R10 no done from refused bytes", n_done, 0);
    fill_random();
    sector(0, 1, '0);
    expect_frames("R10 next sector", 1, 0, 0);

    // R11 restart partway through
    for (int t = 0; t < 2; t++) begin
      fill_random();
      n_short = 0; n_done = 0;
      check_en = 0; swap_order = 0;
      pulse_start();
      stream(t == 0 ? 100 : 300);
      n_short = 0;
      fill_random();
      sector(1, 0, good_store(0));
      chk(n_short == 1, "R11 short pulse", n_short, 1);
      expect_frames("R11 restart", 0, 0, 0);
    end

    report_sum();
    $finish;
  end
endmodule